// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This debug block watches every bus cycle and compares it against break conditions held in two independent channels, A and B. Each channel compares the cycle's address under a bit mask and its 8-bit address-space identifier. It also filters the cycle by three 2-bit attribute selectors: which bus carried the cycle (L or I), whether it is an instruction fetch or a data access, and whether it reads or writes. Channel B also compares the cycle's data under its own mask.

When a channel's conditions hold, the block sets one of that channel's sticky match flags, chosen by the bus the cycle ran on. It also raises a one-cycle break request toward the CPU. When both channels hit in the same cycle, both channels' flags are set and only one request is raised. Software sets up the conditions and reads or clears the flags through a small register port. Writes take effect at the next clock edge and reads are combinational.

Register map (index on `reg_addr`; channel A uses 0 to 3, channel B uses 4 to 7):
- 0 / 4: break address
- 1 / 5: address mask (1 = bit ignored)
- 2 / 6: identifier, bits [7:0]
- 3 / 7: cycle selectors. Bus select is bits [1:0], with bit0 = L bus and bit1 = I bus. Access kind is bits [3:2], with bit2 = fetch and bit3 = data. Direction is bits [5:4], with bit4 = read and bit5 = write.
- 8: channel B data value
- 9: channel B data mask (1 = bit ignored)
- 10: flags. Bit0 = A on the L bus, bit1 = A on the I bus, bit2 = B on the L bus, bit3 = B on the I bus.

Top module: `bus_break_unit`

## Requirements
- R1: After reset, every register reads 0 and `brk_req` is 0. Because every selector is 00, no bus cycle sets a flag or raises a request.
- R2: A valid cycle passes a channel's attribute filter only if three selector bits are all 1. These are the bus-select bit for its bus (bit0 L, bit1 I), the kind bit for its kind (bit2 fetch, bit3 data) and the direction bit (bit4 read, bit5 write). As a result, a group of 00 disables the channel.
- R3: Address bits whose mask bit is 1 are ignored. Every other address bit must equal the channel's break address.
- R4: The 8-bit identifier of the cycle must equal the channel's identifier register exactly; a single differing bit prevents a match.
- R5: Channel B also requires the cycle data to equal register 8 in every bit that is 0 in register 9. Channel A ignores the data bus.
- R6: A matching cycle sets the flag of its channel for the bus it ran on: flag bit 2·c when `bus_ibus`=0 and bit 2·c+1 when `bus_ibus`=1, with c=0 for A and c=1 for B.
- R7: Flags are sticky. A non-matching cycle leaves them unchanged, and so does writing 1 to a flag bit. Writing 0 to a flag bit clears only that bit.
- R8: `brk_req` is high in exactly the cycle after a matching cycle. A cycle in which both channels match raises a single request and sets both channels' flags.
- R9: A written value is read back from the next cycle on, truncated to the register's width: identifier 8 bits, selectors 6 bits, flags 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_ibus | input | 1 | 1 = cycle on the I bus, 0 = L bus |
| bus_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Cycle address |
| bus_asid | input | 8 | Cycle address-space identifier |
| bus_data | input | 32 | Cycle data |
| brk_req | output | 1 | Break request pulse toward the CPU |

## Verification
The hardest situation to reach from the ports is a single bus cycle that satisfies both channels at once. Channel B needs its data compare to pass on top of the shared address and identifier, so the bench points both channels at one address and identifier. It gives B the data value of that cycle and then checks for one request with both channels' flags for the same bus. The selector space is swept fully: all 64 selector codes against all 8 attribute combinations on each channel. Every address and data bit is flipped alone against the masks.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  localparam int NCH         = 2;
  localparam int RA_W        = 4;
  localparam int RW          = 32;
  localparam int ASID_W      = 8;
  localparam int REGS_PER_CH = 4;
  localparam int OFS_ADDR    = 0;
  localparam int OFS_MASK    = 1;
  localparam int OFS_ASID    = 2;
  localparam int OFS_CYC     = 3;
  localparam int REG_DATA    = NCH * REGS_PER_CH;
  localparam int REG_DMASK   = REG_DATA + 1;
  localparam int REG_FLAGS   = REG_DATA + 2;
  localparam int FLAG_W      = 2 * NCH;
  localparam int CYC_W       = 6;

  // bus [1:0]: bit0 L, bit1 I; kind [3:2]: bit2 fetch, bit3 data; dir [5:4]: bit4 read, bit5 write
  typedef struct packed {
    logic [1:0] dir;
    logic [1:0] kind;
    logic [1:0] bus;
  } cyc_sel_t;

  function automatic logic sel_pick(input logic [1:0] grp, input logic idx);
    return grp[idx];
  endfunction

  function automatic logic attr_pass(input cyc_sel_t c, input logic ibus,
                                     input logic ifetch, input logic wr);
    return sel_pick(c.bus, ibus) & sel_pick(c.kind, ~ifetch) & sel_pick(c.dir, wr);
  endfunction

  function automatic logic group_off(input cyc_sel_t c);
    return (c.bus == 2'b00) || (c.kind == 2'b00) || (c.dir == 2'b00);
  endfunction
endpackage

// File: rtl/bbu_chan.sv
module bbu_chan
  import bbu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [AW-1:0]     cfg_amask,
  input  logic [ASID_W-1:0] cfg_asid,
  input  cyc_sel_t          cfg_cyc,
  input  logic [DW-1:0]     cfg_data,
  input  logic [DW-1:0]     cfg_dmask,
  input  logic              bus_valid,
  input  logic              bus_ibus,
  input  logic              bus_ifetch,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [ASID_W-1:0] bus_asid,
  input  logic [DW-1:0]     bus_data,
  output logic              hit_l,
  output logic              hit_i
);
  function automatic logic addr_eq(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                   input logic [AW-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  function automatic logic data_eq(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                   input logic [DW-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  logic attr_ok, addr_ok, asid_ok, data_ok, hit;

  assign attr_ok = attr_pass(cfg_cyc, bus_ibus, bus_ifetch, bus_write);
  assign addr_ok = addr_eq(bus_addr, cfg_addr, cfg_amask);
  assign asid_ok = (bus_asid == cfg_asid);

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = data_eq(bus_data, cfg_data, cfg_dmask);
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{cfg_data, cfg_dmask, bus_data};
      assign data_ok = 1'b1;
    end
  endgenerate

  assign hit   = bus_valid & attr_ok & addr_ok & asid_ok & data_ok;
  assign hit_l = hit & ~bus_ibus;
  assign hit_i = hit & bus_ibus;

  // R2: a zero selector group keeps the channel silent
  a_r2_group_off: assert property (@(posedge clk) disable iff (!rst_n)
    group_off(cfg_cyc) |-> !(hit_l || hit_i));

  // R3: any hit agrees with the break address on every unmasked bit
  a_r3_addr_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_l || hit_i) |-> (((bus_addr ^ cfg_addr) & ~cfg_amask) == '0));

  // R4: any hit carries the programmed identifier
  a_r4_asid_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_l || hit_i) |-> (bus_asid == cfg_asid));

  // R6: a hit is attributed to exactly one bus
  a_r6_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_l, hit_i}));
endmodule

// File: rtl/bbu_regs.sv
module bbu_regs
  import bbu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [RA_W-1:0]                 reg_addr,
  input  logic [RW-1:0]                   reg_wdata,
  output logic [RW-1:0]                   reg_rdata,
  input  logic [FLAG_W-1:0]               flag_set,
  output logic [NCH-1:0][AW-1:0]          cfg_addr,
  output logic [NCH-1:0][AW-1:0]          cfg_amask,
  output logic [NCH-1:0][ASID_W-1:0]      cfg_asid,
  output cyc_sel_t [NCH-1:0]              cfg_cyc,
  output logic [DW-1:0]                   cfg_data,
  output logic [DW-1:0]                   cfg_dmask,
  output logic [FLAG_W-1:0]               flags
);
  logic              flag_wr;
  logic [FLAG_W-1:0] flag_keep;

  assign flag_wr   = reg_we && (reg_addr == RA_W'(REG_FLAGS));
  assign flag_keep = flag_wr ? reg_wdata[FLAG_W-1:0] : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_addr  <= '0;
      cfg_amask <= '0;
      cfg_asid  <= '0;
      cfg_cyc   <= '0;
      cfg_data  <= '0;
      cfg_dmask <= '0;
      flags     <= '0;
    end else begin
      if (reg_we) begin
        for (int c = 0; c < NCH; c++) begin
          if (reg_addr == RA_W'(c * REGS_PER_CH + OFS_ADDR)) cfg_addr[c]  <= reg_wdata[AW-1:0];
          if (reg_addr == RA_W'(c * REGS_PER_CH + OFS_MASK)) cfg_amask[c] <= reg_wdata[AW-1:0];
          if (reg_addr == RA_W'(c * REGS_PER_CH + OFS_ASID)) cfg_asid[c]  <= reg_wdata[ASID_W-1:0];
          if (reg_addr == RA_W'(c * REGS_PER_CH + OFS_CYC))  cfg_cyc[c]   <= cyc_sel_t'(reg_wdata[CYC_W-1:0]);
        end
        if (reg_addr == RA_W'(REG_DATA))  cfg_data  <= reg_wdata[DW-1:0];
        if (reg_addr == RA_W'(REG_DMASK)) cfg_dmask <= reg_wdata[DW-1:0];
      end
      flags <= (flags & flag_keep) | flag_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == RA_W'(c * REGS_PER_CH + OFS_ADDR)) reg_rdata = RW'(cfg_addr[c]);
      if (reg_addr == RA_W'(c * REGS_PER_CH + OFS_MASK)) reg_rdata = RW'(cfg_amask[c]);
      if (reg_addr == RA_W'(c * REGS_PER_CH + OFS_ASID)) reg_rdata = RW'(cfg_asid[c]);
      if (reg_addr == RA_W'(c * REGS_PER_CH + OFS_CYC))  reg_rdata = RW'(cfg_cyc[c]);
    end
    if (reg_addr == RA_W'(REG_DATA))  reg_rdata = RW'(cfg_data);
    if (reg_addr == RA_W'(REG_DMASK)) reg_rdata = RW'(cfg_dmask);
    if (reg_addr == RA_W'(REG_FLAGS)) reg_rdata = RW'(flags);
  end

  generate
    for (genvar k = 0; k < FLAG_W; k++) begin : g_flag_chk
      // R7: a set flag survives unless a 0 is written to it
      a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[k] && !(flag_wr && !reg_wdata[k])) |=> flags[k]);
      // R6: a hit on this flag's channel and bus sets it
      a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[k] |=> flags[k]);
      // R7: a flag only rises because of a hit
      a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[k] && !flag_set[k]) |=> !flags[k]);
    end
  endgenerate
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_ibus,
  input  logic              bus_ifetch,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [ASID_W-1:0] bus_asid,
  input  logic [DW-1:0]     bus_data,
  output logic              brk_req
);
  logic [NCH-1:0][AW-1:0]     cfg_addr;
  logic [NCH-1:0][AW-1:0]     cfg_amask;
  logic [NCH-1:0][ASID_W-1:0] cfg_asid;
  cyc_sel_t [NCH-1:0]         cfg_cyc;
  logic [DW-1:0]              cfg_data;
  logic [DW-1:0]              cfg_dmask;
  logic [FLAG_W-1:0]          flags;
  logic [FLAG_W-1:0]          flag_set;
  logic [NCH-1:0]             chan_hit;

  bbu_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .flag_set  (flag_set),
    .cfg_addr  (cfg_addr),
    .cfg_amask (cfg_amask),
    .cfg_asid  (cfg_asid),
    .cfg_cyc   (cfg_cyc),
    .cfg_data  (cfg_data),
    .cfg_dmask (cfg_dmask),
    .flags     (flags)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic h_l, h_i;
      bbu_chan #(.AW(AW), .DW(DW), .HAS_DATA(c == NCH - 1)) chan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_addr   (cfg_addr[c]),
        .cfg_amask  (cfg_amask[c]),
        .cfg_asid   (cfg_asid[c]),
        .cfg_cyc    (cfg_cyc[c]),
        .cfg_data   (cfg_data),
        .cfg_dmask  (cfg_dmask),
        .bus_valid  (bus_valid),
        .bus_ibus   (bus_ibus),
        .bus_ifetch (bus_ifetch),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_asid   (bus_asid),
        .bus_data   (bus_data),
        .hit_l      (h_l),
        .hit_i      (h_i)
      );
      assign flag_set[2*c]   = h_l;
      assign flag_set[2*c+1] = h_i;
      assign chan_hit[c]     = h_l | h_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) brk_req <= 1'b0;
    else        brk_req <= |chan_hit;
  end

  // R8: every newly raised flag comes with a request in the same cycle
  a_r8_flag_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~$past(flags))) |-> brk_req);

  // R8: no request without a bus cycle in the previous clock
  a_r8_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid) |-> !brk_req);

  // R8: both channels hitting together give one request and flags on both channels
  a_r8_dual: assert property (@(posedge clk) disable iff (!rst_n)
    (&chan_hit) |=> (brk_req && (|flags[1:0]) && (|flags[3:2])));

  // R1: while held in reset nothing is requested
  a_r1_reset_quiet: assert property (@(posedge clk)
    !$past(rst_n) |-> !brk_req);
endmodule

// File: tb/bus_break_unit_tb.sv
`timescale 1ns/1ps
module bus_break_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic        bus_ibus = 1'b0;
  logic        bus_ifetch = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [7:0]  bus_asid = '0;
  logic [31:0] bus_data = '0;
  logic        brk_req;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_break_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_ibus(bus_ibus), .bus_ifetch(bus_ifetch), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_asid(bus_asid), .bus_data(bus_data),
    .brk_req(brk_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = a[3:0];
    #1;
    v = reg_rdata;
  endtask

  // selector pass, written per group from the bit meanings of R2
  function automatic bit exp_attr(input int cyc, input bit ib, input bit f, input bit w);
    int gb, gk, gd;
    bit okb, okk, okd;
    gb = cyc % 4; gk = (cyc / 4) % 4; gd = (cyc / 16) % 4;
    okb = ib ? (gb >= 2) : (gb % 2 == 1);
    okk = f  ? (gk % 2 == 1) : (gk >= 2);
    okd = w  ? (gd >= 2) : (gd % 2 == 1);
    return okb && okk && okd;
  endfunction

  task automatic apply(input bit ib, input bit f, input bit w, input logic [31:0] a,
                       input logic [7:0] s, input logic [31:0] d,
                       input bit exp_req, input logic [31:0] exp_fl, input string tag);
    logic [31:0] v;
    @(negedge clk);
    bus_valid = 1'b1; bus_ibus = ib; bus_ifetch = f; bus_write = w;
    bus_addr = a; bus_asid = s; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
    chk({tag, " R8 request"}, {31'd0, brk_req}, {31'd0, exp_req});
    rd(10, v);
    chk({tag, " R6 flags"}, v, exp_fl);
    @(negedge clk);
    chk({tag, " R8 pulse end"}, {31'd0, brk_req}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values and an inert block
    chk("R1 brk_req", {31'd0, brk_req}, 32'd0);
    for (int a = 0; a <= 10; a++) begin
      rd(a, v);
      chk($sformatf("R1 reg %0d", a), v, 32'd0);
    end
    for (int t = 0; t < 8; t++)
      apply(t[2], t[1], t[0], 32'd0, 8'd0, 32'd0, 1'b0, 32'd0, "R1 idle");

    // R2/R6 channel A selector sweep
    wr(0, 32'h0000_1000); wr(1, 32'd0); wr(2, 32'h5A); wr(7, 32'd0);
    for (int cyc = 0; cyc < 64; cyc++) begin
      wr(3, cyc);
      for (int t = 0; t < 8; t++) begin
        bit e;
        e = exp_attr(cyc, t[2], t[1], t[0]);
        wr(10, 32'd0);
        apply(t[2], t[1], t[0], 32'h0000_1000, 8'h5A, 32'd0, e,
              e ? (t[2] ? 32'd2 : 32'd1) : 32'd0, "R2 chanA");
      end
    end

    // R2/R6 channel B selector sweep
    wr(3, 32'd0);
    wr(4, 32'h0000_2000); wr(5, 32'd0); wr(6, 32'hC3);
    wr(8, 32'hCAFE_0000); wr(9, 32'd0);
    for (int cyc = 0; cyc < 64; cyc++) begin
      wr(7, cyc);
      for (int t = 0; t < 8; t++) begin
        bit e;
        e = exp_attr(cyc, t[2], t[1], t[0]);
        wr(10, 32'd0);
        apply(t[2], t[1], t[0], 32'h0000_2000, 8'hC3, 32'hCAFE_0000, e,
              e ? (t[2] ? 32'd8 : 32'd4) : 32'd0, "R2 chanB");
      end
    end

    // R3 address mask on channel A
    wr(7, 32'd0); wr(3, 32'h3F); wr(1, 32'h0000_000F);
    for (int k = 0; k < 32; k++) begin
      bit e;
      e = (k < 4);
      wr(10, 32'd0);
      apply(1'b0, 1'b1, 1'b0, 32'h0000_1000 ^ (32'd1 << k), 8'h5A, 32'd0, e,
            e ? 32'd1 : 32'd0, "R3 addr bit");
    end

    // R4 identifier equality
    wr(1, 32'd0);
    for (int k = 0; k < 8; k++) begin
      wr(10, 32'd0);
      apply(1'b1, 1'b0, 1'b1, 32'h0000_1000, 8'h5A ^ (8'd1 << k), 32'd0, 1'b0, 32'd0,
            "R4 asid bit");
    end
    wr(10, 32'd0);
    apply(1'b1, 1'b0, 1'b1, 32'h0000_1000, 8'h5A, 32'd0, 1'b1, 32'd2, "R4 asid equal");

    // R5 channel A ignores data
    wr(10, 32'd0);
    apply(1'b0, 1'b0, 1'b0, 32'h0000_1000, 8'h5A, 32'h1234_5678, 1'b1, 32'd1, "R5 chanA data");

    // R5 channel B data mask
    wr(3, 32'd0); wr(7, 32'h3F); wr(9, 32'h0000_FF00);
    for (int k = 0; k < 32; k++) begin
      bit e;
      e = (k >= 8) && (k <= 15);
      wr(10, 32'd0);
      apply(1'b1, 1'b1, 1'b0, 32'h0000_2000, 8'hC3, 32'hCAFE_0000 ^ (32'd1 << k), e,
            e ? 32'd8 : 32'd0, "R5 data bit");
    end

    // R8 both channels in one cycle
    wr(9, 32'd0); wr(4, 32'h0000_1000); wr(6, 32'h5A); wr(3, 32'h3F);
    wr(10, 32'd0);
    apply(1'b0, 1'b1, 1'b0, 32'h0000_1000, 8'h5A, 32'hCAFE_0000, 1'b1, 32'h5, "R8 dual L");
    wr(10, 32'd0);
    apply(1'b1, 1'b0, 1'b1, 32'h0000_1000, 8'h5A, 32'hCAFE_0000, 1'b1, 32'hA, "R8 dual I");

    // R7 sticky flags
    wr(7, 32'd0); wr(10, 32'd0);
    apply(1'b0, 1'b1, 1'b0, 32'h0000_1000, 8'h5A, 32'd0, 1'b1, 32'd1, "R7 first hit");
    apply(1'b0, 1'b1, 1'b0, 32'h0000_1001, 8'h5A, 32'd0, 1'b0, 32'd1, "R7 miss keeps");
    wr(10, 32'hF);
    rd(10, v); chk("R7 write ones", v, 32'd1);
    wr(3, 32'd0); wr(7, 32'h3F);
    apply(1'b1, 1'b1, 1'b0, 32'h0000_1000, 8'h5A, 32'hCAFE_0000, 1'b1, 32'd9, "R7 add B");
    wr(10, 32'hE);
    rd(10, v); chk("R7 clear bit0", v, 32'd8);
    wr(10, 32'd0);
    rd(10, v); chk("R7 clear all", v, 32'd0);

    // R9 write then read back with truncation
    wr(0, 32'hDEAD_BEEF); rd(0, v); chk("R9 addrA", v, 32'hDEAD_BEEF);
    wr(5, 32'h0F0F_00FF); rd(5, v); chk("R9 maskB", v, 32'h0F0F_00FF);
    wr(2, 32'h0000_01A5); rd(2, v); chk("R9 asidA", v, 32'h0000_00A5);
    wr(7, 32'h0000_00FF); rd(7, v); chk("R9 cycB", v, 32'h0000_003F);
    wr(8, 32'h1357_9BDF); rd(8, v); chk("R9 data", v, 32'h1357_9BDF);
    wr(10, 32'hFFFF_FFF0); rd(10, v); chk("R9 flags", v, 32'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule